// File: doc/BRIEF.md
# Serial Receive Interrupt Mode Controller

This block sits between a serial receiver and its host and decides when the receiver asks for service. Each received character lands in a small queue with three per-character error markers: parity, framing and end of frame. The host sees the oldest character at the queue head and removes it with a read strobe. An eight-bit control register selects one of four interrupt policies in bits 4:3 and, in bit 2, whether a parity error counts as a special condition. The block latches error status that stays set until the host clears it.

A character that carries a special condition can lock the queue head. It then stays visible, and reads are refused until the host sends an error-clear strobe. This lets software tie each error to the character that caused it. When every character interrupts, the lock is skipped and only the sticky status keeps the error. A re-arm strobe reopens the one-shot first-character policy.

Top module: `rx_irq_mode_ctrl`

## Requirements
- R1: A control write stores all eight bits of `ctl_wdata`, and they show on `ctl_q` from the next cycle. Bits 4:3 choose the policy (00 off, 01 first character, 10 every character, 11 special only). Bit 2 set makes a parity error special. The other bits are only stored.
- R2: With policy 00, `irq` stays low. `spec_vec` still rises when a special condition is latched.
- R3: With policy 01, a control write that selects 01, or a `rearm` strobe, arms the block. While it is armed and the queue holds a character, `irq` is high. Reading a character disarms it, and later characters raise no request until it is armed again.
- R4: With policy 10, `irq` is high while the queue holds any character or `spec_vec` is high.
- R5: With policy 11, `irq` follows `spec_vec` only. Clean characters never raise it.
- R6: A special condition is any of these: overrun, framing error, end of frame, or parity error when bit 2 is set. `spec_vec` is high while any such latched status bit is set.
- R7: A character that arrives with `rx_sync_strip` high is discarded. It never enters the queue and causes no request.
- R8: With any policy except 10, a head character that carries a special condition ignores `rd_en` until `err_reset`. `err_reset` clears that character's markers so that the next read removes it. With policy 10, such a character is read normally.
- R9: The four status bits `stat_ovr`, `stat_perr`, `stat_ferr` and `stat_eof` are sticky, and `err_reset` clears them. A bit that is set in the same cycle as the clear stays set.
- R10: A control write that selects policy 00 clears the latched status, so a pending special condition is dropped.
- R11: The queue holds 3 characters. A character that arrives while it is full is dropped and sets `stat_ovr`. A read in the same cycle does not prevent this.
- R12: A synchronous reset clears the control register, the queue, the status and `irq`. `irq` is registered: it follows its condition one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_q | output | 8 | Stored control register |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Character has a parity error |
| rx_ferr | input | 1 | Character has a framing error |
| rx_eof | input | 1 | Character ends a frame |
| rx_sync_strip | input | 1 | Character is a stripped sync pattern |
| rd_en | input | 1 | Host reads the head character |
| err_reset | input | 1 | Error-clear strobe |
| rearm | input | 1 | Re-arm first-character policy strobe |
| head_valid | output | 1 | Queue holds a character |
| head_data | output | 8 | Head character, zero when the queue is empty |
| irq | output | 1 | Registered interrupt request level |
| spec_vec | output | 1 | Special condition indication |
| stat_ovr | output | 1 | Sticky overrun |
| stat_perr | output | 1 | Sticky parity error |
| stat_ferr | output | 1 | Sticky framing error |
| stat_eof | output | 1 | Sticky end of frame |

## Verification
If the arm flag is stuck or lost, `irq` shows it two clocks after the first character or the first read under policy 01. A head marker that is wrongly kept or cleared shows up at once: the next `rd_en` fails to change `head_data`, or a refused read advances it. Queue occupancy errors reach `stat_ovr` one cycle after the fourth arrival. A status bit that fails to clear or set shows on `spec_vec` in the cycle after the strobe.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  typedef enum logic [1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_ALL   = 2'b10,
    RXI_SPEC  = 2'b11
  } rxi_mode_e;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic eof;
  } rxi_flags_t;
endpackage

// File: rtl/rxi_fifo.sv
module rxi_fifo #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic [DW-1:0]         push_data,
  input  rxi_pkg::rxi_flags_t   push_flags,
  input  logic                  pop,
  input  logic                  clr_head,
  output logic                  head_valid,
  output logic [DW-1:0]         head_data,
  output rxi_pkg::rxi_flags_t   head_flags,
  output logic                  full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0]       mem   [DEPTH];
  rxi_pkg::rxi_flags_t flg   [DEPTH];
  logic [PW-1:0]       wr_ptr, rd_ptr;
  logic [CW-1:0]       count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // data array: one write port, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  // marker array kept in flops so the head entry can be cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) flg[i] <= '0;
    end else begin
      if (clr_head) flg[rd_ptr] <= '0;
      if (push)     flg[wr_ptr] <= push_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_valid = (count != '0);
  assign full       = (count == CW'(DEPTH));
  assign head_data  = head_valid ? mem[rd_ptr] : '0;
  assign head_flags = head_valid ? flg[rd_ptr] : '0;
endmodule

// File: rtl/rxi_status.sv
module rxi_status #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic          clr,
  output logic [NF-1:0] q
);
  // a set in the clearing cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~{NF{clr}}) | set;
  end
endmodule

// File: rtl/rxi_irq.sv
module rxi_irq (
  input  logic               clk,
  input  logic               rst,
  input  rxi_pkg::rxi_mode_e mode,
  input  logic               ctl_we,
  input  rxi_pkg::rxi_mode_e wr_mode,
  input  logic               rearm,
  input  logic               pop_done,
  input  logic               nonempty,
  input  logic               spec,
  output logic               irq
);
  import rxi_pkg::*;

  logic armed;
  logic irq_d;

  always_ff @(posedge clk) begin
    if (rst)                                armed <= 1'b0;
    else if (ctl_we)                        armed <= (wr_mode == RXI_FIRST);
    else if (rearm)                         armed <= 1'b1;
    else if (pop_done && mode == RXI_FIRST) armed <= 1'b0;
  end

  always_comb begin
    case (mode)
      RXI_OFF:   irq_d = 1'b0;
      RXI_FIRST: irq_d = (armed & nonempty) | spec;
      RXI_ALL:   irq_d = nonempty | spec;
      default:   irq_d = spec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_d;
  end
endmodule

// File: rtl/rx_irq_mode_ctrl.sv
module rx_irq_mode_ctrl #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_q,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_eof,
  input  logic          rx_sync_strip,
  input  logic          rd_en,
  input  logic          err_reset,
  input  logic          rearm,
  output logic          head_valid,
  output logic [DW-1:0] head_data,
  output logic          irq,
  output logic          spec_vec,
  output logic          stat_ovr,
  output logic          stat_perr,
  output logic          stat_ferr,
  output logic          stat_eof
);
  import rxi_pkg::*;

  localparam int MODE_LO = 3;
  localparam int PAR_BIT = 2;
  localparam int NSTAT   = 4;

  logic [7:0]       ctl_r;
  rxi_mode_e        mode, wr_mode;
  logic             par_spec;
  logic             accept, push, ovf, pop, full;
  logic             head_special, hold;
  rxi_flags_t       head_flags, in_flags;
  logic [NSTAT-1:0] st_set, st_q;
  logic             st_clr;

  always_ff @(posedge clk) begin
    if (rst)         ctl_r <= '0;
    else if (ctl_we) ctl_r <= ctl_wdata;
  end

  assign ctl_q    = ctl_r;
  assign mode     = rxi_mode_e'(ctl_r[MODE_LO +: 2]);
  assign wr_mode  = rxi_mode_e'(ctl_wdata[MODE_LO +: 2]);
  assign par_spec = ctl_r[PAR_BIT];

  assign accept   = rx_valid & ~rx_sync_strip;
  assign push     = accept & ~full;
  assign ovf      = accept & full;
  assign in_flags = '{perr: rx_perr, ferr: rx_ferr, eof: rx_eof};

  assign head_special = head_valid &
                        (head_flags.ferr | head_flags.eof | (head_flags.perr & par_spec));
  assign hold = head_special & (mode != RXI_ALL);
  assign pop  = rd_en & head_valid & ~hold;

  rxi_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_data  (rx_data),
    .push_flags (in_flags),
    .pop        (pop),
    .clr_head   (err_reset & head_valid),
    .head_valid (head_valid),
    .head_data  (head_data),
    .head_flags (head_flags),
    .full       (full)
  );

  assign st_set = {ovf, push & rx_perr, push & rx_ferr, push & rx_eof};
  assign st_clr = err_reset | (ctl_we & (wr_mode == RXI_OFF));

  rxi_status #(.NF(NSTAT)) stat_i (
    .clk (clk),
    .rst (rst),
    .set (st_set),
    .clr (st_clr),
    .q   (st_q)
  );

  assign {stat_ovr, stat_perr, stat_ferr, stat_eof} = st_q;
  assign spec_vec = stat_ovr | stat_ferr | stat_eof | (stat_perr & par_spec);

  rxi_irq irq_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .ctl_we   (ctl_we),
    .wr_mode  (wr_mode),
    .rearm    (rearm),
    .pop_done (pop),
    .nonempty (head_valid),
    .spec     (spec_vec),
    .irq      (irq)
  );
endmodule

// File: rtl/rx_irq_mode_ctrl_chk.sv
module rx_irq_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_q,
  input logic       rx_valid,
  input logic       rx_sync_strip,
  input logic       rd_en,
  input logic       err_reset,
  input logic       head_valid,
  input logic [7:0] head_data,
  input logic       head_special,
  input logic       full,
  input logic       irq,
  input logic       spec_vec,
  input logic       stat_ovr,
  input logic       stat_perr,
  input logic       stat_ferr,
  input logic       stat_eof
);
  assert_ctl_store_R1: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_q == $past(ctl_wdata)));

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[4:3] == 2'b00) |=> !irq);

  assert_all_chars_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[4:3] == 2'b10 && head_valid) |=> irq);

  assert_spec_only_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[4:3] == 2'b11 && !spec_vec) |=> !irq);

  assert_strip_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sync_strip && !head_valid) |=> !head_valid);

  assert_head_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[4:3] != 2'b10 && head_special && rd_en) |=> (head_valid && $stable(head_data)));

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (err_reset && !rx_valid) |=> !(stat_ovr || stat_perr || stat_ferr || stat_eof));

  assert_off_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[4:3] == 2'b00 && !rx_valid) |=> !spec_vec);

  assert_overrun_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_sync_strip && full) |=> stat_ovr);
endmodule

bind rx_irq_mode_ctrl rx_irq_mode_ctrl_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .ctl_we        (ctl_we),
  .ctl_wdata     (ctl_wdata),
  .ctl_q         (ctl_q),
  .rx_valid      (rx_valid),
  .rx_sync_strip (rx_sync_strip),
  .rd_en         (rd_en),
  .err_reset     (err_reset),
  .head_valid    (head_valid),
  .head_data     (head_data),
  .head_special  (head_special),
  .full          (full),
  .irq           (irq),
  .spec_vec      (spec_vec),
  .stat_ovr      (stat_ovr),
  .stat_perr     (stat_perr),
  .stat_ferr     (stat_ferr),
  .stat_eof      (stat_eof)
);

// File: tb/rx_irq_mode_ctrl_tb_top.sv
module rx_irq_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 42;

  // vector: op[31:28] arg[27:20] flags{pe,fe,eo,st}[19:16] req[15:12]
  //         expect{0,irq,spec,hv}[11:8] head_data[7:0]
  // op: 0 control write, 1 receive, 2 read, 3 error clear, 4 re-arm
  localparam logic [31:0] VEC [NV] = '{
    32'h01001000, // R1 select every-character policy
    32'h1A5045A5, // R4
    32'h13C045A5, // R4
    32'h2000453C, // R4
    32'h20004000, // R4 empty, no request
    32'h17717000, // R7 stripped sync character
    32'h00803000, // R3 first-character policy, armed
    32'h11103511, // R3
    32'h12203511, // R3
    32'h20003122, // R3 read disarms
    32'h13303122, // R3 no request for later character
    32'h40003522, // R3 re-arm
    32'h20003133, // R3
    32'h20003000, // R3
    32'h14446744, // R6 framing error is special
    32'h15508744, // R8
    32'h20008744, // R8 read refused
    32'h30009144, // R9 error clear
    32'h20008155, // R8 released
    32'h20008000, // R8
    32'h01805000, // R5 special-only policy
    32'h16605166, // R5 clean char no request
    32'h16786166, // R6 parity not special yet
    32'h20008167, // R8 not held
    32'h20008000, // R8
    32'h01C06600, // R6 parity now special
    32'h30009000, // R9
    32'h16886768, // R6
    32'h20008768, // R8 held
    32'h0000A168, // R10 disable clears pending
    32'h16922368, // R2 special seen, no request
    32'h30009168, // R9
    32'h20008169, // R8
    32'h20008169, // R8 end-of-frame head held
    32'h01008569, // R8 every-character policy: not held
    32'h20008000, // R8
    32'h1010B501, // R11
    32'h1020B501, // R11
    32'h1030B501, // R11 full
    32'h1040B701, // R11 overrun
    32'h2000B702, // R11
    32'h30009502  // R9
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_q;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_eof = 1'b0, rx_sync_strip = 1'b0;
  logic       rd_en = 1'b0, err_reset = 1'b0, rearm = 1'b0;
  logic       head_valid;
  logic [7:0] head_data;
  logic       irq, spec_vec, stat_ovr, stat_perr, stat_ferr, stat_eof;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_irq_mode_ctrl dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_eof(rx_eof), .rx_sync_strip(rx_sync_strip), .rd_en(rd_en),
    .err_reset(err_reset), .rearm(rearm), .head_valid(head_valid),
    .head_data(head_data), .irq(irq), .spec_vec(spec_vec), .stat_ovr(stat_ovr),
    .stat_perr(stat_perr), .stat_ferr(stat_ferr), .stat_eof(stat_eof)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive at a falling edge, hold one cycle, then wait one more for irq
  task automatic do_op(input logic [3:0] op, input logic [7:0] arg,
                       input logic [3:0] fl, input logic clr_too);
    ctl_we        = (op == 4'd0);
    ctl_wdata     = arg;
    rx_valid      = (op == 4'd1);
    rx_data       = arg;
    {rx_perr, rx_ferr, rx_eof, rx_sync_strip} = fl;
    rd_en         = (op == 4'd2);
    err_reset     = (op == 4'd3) | clr_too;
    rearm         = (op == 4'd4);
    @(negedge clk);
    ctl_we = 1'b0; rx_valid = 1'b0; rd_en = 1'b0; err_reset = 1'b0; rearm = 1'b0;
    {rx_perr, rx_ferr, rx_eof, rx_sync_strip} = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    check("R12", "irq", 32'(irq), 32'd0);
    check("R12", "spec_vec", 32'(spec_vec), 32'd0);
    check("R12", "head_valid", 32'(head_valid), 32'd0);
    check("R12", "ctl_q", 32'(ctl_q), 32'd0);
    check("R12", "status", 32'({stat_ovr, stat_perr, stat_ferr, stat_eof}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d(vec %0d)", v[15:12], i);
      do_op(v[31:28], v[27:20], v[19:16], 1'b0);
      check(tag, "irq", 32'(irq), 32'(v[10]));
      check(tag, "spec_vec", 32'(spec_vec), 32'(v[9]));
      check(tag, "head_valid", 32'(head_valid), 32'(v[8]));
      check(tag, "head_data", 32'(head_data), 32'(v[7:0]));
    end

    // R1 reserved bits are stored
    do_reset();
    do_op(4'd0, 8'hE7, 4'h0, 1'b0);
    check("R1", "ctl_q", 32'(ctl_q), 32'hE7);

    // R9 a new error wins over a simultaneous clear
    do_reset();
    do_op(4'd0, 8'h10, 4'h0, 1'b0);
    do_op(4'd1, 8'h5A, 4'h4, 1'b1);
    check("R9", "stat_ferr", 32'(stat_ferr), 32'd1);
    check("R9", "spec_vec", 32'(spec_vec), 32'd1);
    do_op(4'd3, 8'h00, 4'h0, 1'b0);
    check("R9", "stat_ferr cleared", 32'(stat_ferr), 32'd0);

    // R11 overrun drops the arriving character and latches status
    do_op(4'd1, 8'h5B, 4'h0, 1'b0);
    do_op(4'd1, 8'h5C, 4'h0, 1'b0);
    check("R11", "stat_ovr before", 32'(stat_ovr), 32'd0);
    do_op(4'd1, 8'h5D, 4'h0, 1'b0);
    check("R11", "stat_ovr", 32'(stat_ovr), 32'd1);
    check("R11", "head_data", 32'(head_data), 32'h5A);
    do_op(4'd2, 8'h00, 4'h0, 1'b0);
    do_op(4'd2, 8'h00, 4'h0, 1'b0);
    do_op(4'd2, 8'h00, 4'h0, 1'b0);
    check("R11", "dropped char absent", 32'(head_valid), 32'd0);

    // R10 disabling drops a pending special under first-character policy
    do_reset();
    do_op(4'd0, 8'h08, 4'h0, 1'b0);
    do_op(4'd1, 8'h70, 4'h4, 1'b0);
    check("R10", "irq pending", 32'(irq), 32'd1);
    do_op(4'd0, 8'h00, 4'h0, 1'b0);
    check("R10", "spec_vec", 32'(spec_vec), 32'd0);
    check("R10", "stat_ferr", 32'(stat_ferr), 32'd0);
    check("R10", "irq", 32'(irq), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule